// File: doc/BRIEF.md
# Dual-Pin Interrupt Controller

This block gathers eight event sources into one status register and drives two interrupt pins from it. Three sources come from the sample data path: data-ready, watermark and overflow. The other five are motion detections: single tap, double tap, activity, inactivity and free fall. An enable register decides which latched events may drive a pin. A steering register sends each event to either pin A or pin B. Each pin is the OR of every enabled, latched event steered to it.

The two groups use different clear rules. A data-path status bit is latched whenever its event occurs, even if the enable bit is 0. It is cleared by a read of the sample data. A detection status bit is latched only while its enable bit is 1. It is cleared by a read of the status register. Data-ready and watermark arrive as levels from the data path. They latch again after a data read while the condition still holds, so the host may need several data reads before they clear. A polarity input inverts both pins.

Top module: `irq_pair_ctrl`

## Requirements
- R1: After reset the status, enable and steering registers are all zero, and both pins are at their inactive level.
- R2: Every register uses this bit order: bit 7 data-ready, bit 6 single tap, bit 5 double tap, bit 4 activity, bit 3 inactivity, bit 2 free fall, bit 1 watermark, bit 0 overflow.
- R3: A detection event (bits 6 to 2) that is present in cycle N sets its status bit at the clock edge ending cycle N, but only if its enable bit is 1 in that cycle. If the enable bit is 0, the status bit does not change.
- R4: A data-path event (bits 7, 1 and 0) sets its status bit at the next clock edge, whatever its enable bit holds.
- R5: Pin A is the OR of the status bits that are enabled and have a steering bit of 0. Pin B is the OR of those that are enabled and have a steering bit of 1.
- R6: A status read clears every detection status bit at the next clock edge. A data read leaves the detection status bits unchanged.
- R7: A data read clears the data-path status bits at the next clock edge. A status read leaves the data-path status bits unchanged. A data-path event that is still present during the data read keeps its bit set.
- R8: If an event arrives in the same cycle as the read that would clear its bit, the event wins and the status bit stays 1.
- R9: When pol_inv is 1, both pins are inverted, so the inactive level becomes 1.
- R10: Writing an enable bit to 0 removes that event from its pin at once. The status bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | 8 | Event inputs, bit order as in R2 |
| en_wr | input | 1 | Write strobe for the enable register |
| map_wr | input | 1 | Write strobe for the steering register |
| wr_data | input | 8 | Data for the register write |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Sample data read strobe |
| pol_inv | input | 1 | 1 makes both pins active low |
| status | output | 8 | Status register |
| irq_a | output | 1 | Interrupt pin A (steering bit 0) |
| irq_b | output | 1 | Interrupt pin B (steering bit 1) |

## Verification
The hardest case to reach is an event that arrives in the same cycle as the read meant to clear it, since two independent strobes must line up. A related case is a data read that arrives while a data-path level is still asserted. The stimulus produces both cases directly: it drives a tap event together with a status read, and it holds data-ready high through a data read. A long random phase then raises events, reads, register writes and polarity changes with independent probabilities, so both kinds of collision happen many more times. A behavioural model checks the pins and the status register on every cycle.

// File: rtl/irq_pair_ctrl.sv
module irq_pair_ctrl #(
  parameter int unsigned NEV = 8,
  parameter logic [NEV-1:0] DATA_MASK = 8'b1000_0011
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt_in,
  input  logic           en_wr,
  input  logic           map_wr,
  input  logic [NEV-1:0] wr_data,
  input  logic           stat_rd,
  input  logic           data_rd,
  input  logic           pol_inv,
  output logic [NEV-1:0] status,
  output logic           irq_a,
  output logic           irq_b
);
  logic [NEV-1:0] en_q, map_q, stat_q;

  wire [NEV-1:0] cap  = evt_in & (DATA_MASK | en_q);
  wire [NEV-1:0] clr  = ({NEV{data_rd}} & DATA_MASK) | ({NEV{stat_rd}} & ~DATA_MASK);
  wire [NEV-1:0] live = stat_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      map_q  <= '0;
    end else begin
      stat_q <= cap | (stat_q & ~clr);
      if (en_wr)  en_q  <= wr_data;
      if (map_wr) map_q <= wr_data;
    end
  end

  assign status = stat_q;
  assign irq_a  = pol_inv ^ (|(live & ~map_q));
  assign irq_b  = pol_inv ^ (|(live & map_q));
endmodule

module irq_pair_ctrl_chk #(
  parameter int unsigned NEV = 8,
  parameter logic [NEV-1:0] DATA_MASK = 8'b1000_0011
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NEV-1:0] evt_in,
  input logic           stat_rd,
  input logic           data_rd,
  input logic           pol_inv,
  input logic [NEV-1:0] status,
  input logic           irq_a,
  input logic           irq_b,
  input logic [NEV-1:0] en_q
);
  AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in & DATA_MASK) != '0 |=> (status & $past(evt_in & DATA_MASK)) == $past(evt_in & DATA_MASK)); // R4
  AST_STAT_RD_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !data_rd) |=> (status & $past(status) & DATA_MASK) == ($past(status) & DATA_MASK)); // R7
  AST_DATA_RD_KEEPS_DET: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !stat_rd) |=> (status & $past(status) & ~DATA_MASK) == ($past(status) & ~DATA_MASK)); // R6
  AST_DET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && (evt_in & en_q & ~DATA_MASK) == '0) |=> (status & ~DATA_MASK) == '0); // R6
  AST_DET_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~DATA_MASK) == '0) |=> (status & ~DATA_MASK & ~$past(en_q)) == '0); // R3
  AST_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & en_q) == '0) |-> (irq_a == pol_inv && irq_b == pol_inv)); // R9
endmodule

bind irq_pair_ctrl irq_pair_ctrl_chk #(.NEV(NEV), .DATA_MASK(DATA_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .stat_rd(stat_rd), .data_rd(data_rd),
  .pol_inv(pol_inv), .status(status), .irq_a(irq_a), .irq_b(irq_b), .en_q(en_q)
);

// File: tb/irq_pair_ctrl_test.sv
module irq_pair_ctrl_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] evt_in = 0, wr_data = 0;
  logic en_wr = 0, map_wr = 0, stat_rd = 0, data_rd = 0, pol_inv = 0;
  logic [7:0] status;
  logic irq_a, irq_b;

  int checks = 0, errors = 0;
  bit m_st[8], m_en[8], m_map[8];

  always #(PERIOD/2) clk = ~clk;

  irq_pair_ctrl uut (.clk(clk), .rst_n(rst_n), .evt_in(evt_in), .en_wr(en_wr), .map_wr(map_wr),
    .wr_data(wr_data), .stat_rd(stat_rd), .data_rd(data_rd), .pol_inv(pol_inv),
    .status(status), .irq_a(irq_a), .irq_b(irq_b));

  function automatic bit is_data(int i);
    return (i == 7 || i == 1 || i == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_st[i] = 0; m_en[i] = 0; m_map[i] = 0; end
    end else begin
      for (int i = 0; i < 8; i++) begin
        bit ev, rd;
        ev = evt_in[i] && (is_data(i) || m_en[i]);
        rd = is_data(i) ? data_rd : stat_rd;
        if (ev) m_st[i] = 1;
        else if (rd) m_st[i] = 0;
      end
      for (int i = 0; i < 8; i++) begin
        if (en_wr) m_en[i] = wr_data[i];
        if (map_wr) m_map[i] = wr_data[i];
      end
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmp_model(string req);
    logic [7:0] st;
    bit pa, pb;
    pa = 0; pb = 0;
    for (int i = 0; i < 8; i++) begin
      st[i] = m_st[i];
      if (m_st[i] && m_en[i]) begin
        if (m_map[i]) pb = 1; else pa = 1;
      end
    end
    chk({req, " status"}, status, st);
    chk({req, " pins"}, {6'd0, irq_b, irq_a}, {6'd0, pb ^ pol_inv, pa ^ pol_inv});
  endtask

  task automatic step(string req, logic [7:0] ev, logic ew, logic mw, logic [7:0] wd,
                      logic sr, logic dr);
    @(negedge clk);
    cmp_model(req);
    evt_in = ev; en_wr = ew; map_wr = mw; wr_data = wd; stat_rd = sr; data_rd = dr;
  endtask

  task automatic idle(string req);
    step(req, 8'h00, 0, 0, 8'h00, 0, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R1");
    chk("R1 status", status, 8'h00);
    chk("R1 pins", {6'd0, irq_b, irq_a}, 8'h00);

    step("R3", 8'b0111_1100, 0, 0, 0, 0, 0);
    idle("R3");
    chk("R3 disabled detect", status, 8'h00);

    step("R4", 8'b1000_0011, 0, 0, 0, 0, 0);
    idle("R4");
    chk("R4 data capture", status, 8'h83);
    chk("R4 pins held off", {6'd0, irq_b, irq_a}, 8'h00);

    step("R5", 8'h00, 1, 0, 8'hFF, 0, 0);
    step("R5", 8'h00, 0, 1, 8'h0F, 0, 0);
    idle("R5");
    chk("R5 pins", {6'd0, irq_b, irq_a}, 8'h03);

    step("R7", 8'h00, 0, 0, 0, 1, 0);
    idle("R7");
    chk("R7 stat read keeps data", status, 8'h83);

    step("R2", 8'h40, 0, 0, 0, 0, 0);
    idle("R2");
    chk("R2 single tap bit6", status, 8'hC3);

    step("R7", 8'h80, 0, 0, 0, 0, 1);
    idle("R7");
    chk("R7 data read with level held", status, 8'hC0);
    chk("R6 data read keeps detect", status & 8'h7C, 8'h40);

    step("R8", 8'h20, 0, 0, 0, 1, 0);
    idle("R8");
    chk("R8 event wins over read", status, 8'hA0);

    pol_inv = 1;
    idle("R9");
    chk("R9 inverted pins", {6'd0, irq_b, irq_a}, 8'h02);

    step("R10", 8'h00, 1, 0, 8'h00, 0, 0);
    idle("R10");
    chk("R10 status kept", status, 8'hA0);
    chk("R10 pins idle", {6'd0, irq_b, irq_a}, 8'h03);
    pol_inv = 0;

    step("R6", 8'h00, 1, 0, 8'h7C, 0, 0);
    step("R6", 8'h00, 0, 0, 0, 1, 0);
    idle("R6");
    chk("R6 stat read clears detect", status, 8'h80);

    for (int n = 0; n < 3000; n++) begin
      logic [7:0] ev, wd;
      ev = $urandom & $urandom;
      wd = $urandom;
      if ($urandom_range(0, 49) == 0) pol_inv = ~pol_inv;
      step("R8 random", ev, $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0, wd,
           $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
    end
    idle("R5 final");
    idle("R5 final");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule